// File: doc/BRIEF.md
# Trigger-Controlled Timer Counter Core

This block is the counting heart of a general-purpose timer. A free-running up-counter runs from zero to an active period value and wraps. Software can start and stop it directly, and it can also let an external trigger pin start, stop or zero the counter. Four separate enable inputs control these actions. The trigger pin passes through a two-flop synchronizer and a noise filter of selectable width, and then goes to an edge/level selector.

The period, compare A, compare B and dead-time values each exist twice. Software writes a buffered copy. The active copy, which the outputs show, takes the buffered values only when an update request is pending and either a trigger-driven clear or a counter wrap occurs. An emergency-stop input latches a halt that freezes the count without zeroing it. Software has to release it before counting can resume.

Top module: `tmcore_trig_counter`

## Requirements
- R1: After reset the count is 0, the counter is stopped, the active period equals the parameter RST_PERIOD (all ones by default), and the active compare A, compare B and dead-time values are 0.
- R2: While running in an edge mode, the count advances by one per clock. When the count equals the active period, it returns to 0 on the next clock, so with period P the sequence repeats every P+1 clocks.
- R3: In an edge mode, a qualifying trigger edge starts a stopped counter when start_en is 1, and stops a running one when stop_en is 1. When both are 1 the edge stops the counter, because stop wins. `sw_stop` likewise wins over `sw_start`.
- R4: A qualifying trigger edge zeroes the count when clr_on_start or clr_on_stop is 1, whatever the values of start_en and stop_en. A clear does not by itself start a stopped counter.
- R5: trig_mode encodes 00 rising edge, 01 falling edge, 10 both edges, 11 level. In level mode a started counter advances only while the filtered trigger is high, and no trigger clear, start or stop takes place.
- R6: The filter width is set by filt_sel: 0 gives 2 clocks, 1 gives 4, 2 gives 8, and 3 to 7 give 16. A trigger level held for fewer clocks than the width is ignored. One held for at least the width is accepted.
- R7: Buffered registers are written with wr_en and wr_sel (0 period, 1 compare A, 2 compare B, 3 dead time). When an update request is pending at a trigger clear, all four active values load in the same clock as the clear. A trigger clear with no pending request leaves them unchanged.
- R8: A pending update not consumed by a trigger clear is applied when the counter wraps, and the request is then dropped. Without a clear or a wrap, the active values do not change.
- R9: estop latches a halt until estop_clr. While halted the count holds, trigger clears are suppressed, and the run state is cleared, so counting resumes only after a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Allow trigger edges to start counting |
| stop_en | input | 1 | Allow trigger edges to stop counting |
| clr_on_start | input | 1 | Zero the count on a start-trigger edge |
| clr_on_stop | input | 1 | Zero the count on a stop-trigger edge |
| trig_mode | input | 2 | 00 rise, 01 fall, 10 both, 11 level |
| filt_sel | input | 3 | Noise filter width select |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| estop | input | 1 | Emergency stop request (latched) |
| estop_clr | input | 1 | Release the latched emergency stop |
| upd_req | input | 1 | Request loading of buffered values |
| wr_en | input | 1 | Write strobe for buffered registers |
| wr_sel | input | 2 | Buffered register select |
| wr_data | input | CNT_W | Write data |
| trig_in | input | 1 | External trigger pin |
| count_o | output | CNT_W | Current count |
| run_o | output | 1 | Counter run state |
| period_o | output | CNT_W | Active period |
| cmp_a_o | output | CNT_W | Active compare A |
| cmp_b_o | output | CNT_W | Active compare B |
| dead_o | output | CNT_W | Active dead time |

## Verification
The assertions check, on every cycle, the following:
- a wrap always lands on zero;
- a trigger clear zeroes the count;
- level mode never produces a clear;
- a load copies the buffered period and consumes the request;
- a halt freezes the count and drops the run state;
- a stop beats a start;
- the filter output moves only toward the synchronized input.

Only the bench's scenarios can show the following:
- the exact filter acceptance threshold for each width;
- the per-mode edge selection;
- the count advancing exactly once per filtered-high clock in level mode;
- wrap sequences across a sweep of periods;
- the full sequence of release and restart after an emergency stop.

// File: rtl/tmcore_pkg.sv
package tmcore_pkg;

  typedef enum logic [1:0] {
    TM_RISE  = 2'b00,
    TM_FALL  = 2'b01,
    TM_BOTH  = 2'b10,
    TM_LEVEL = 2'b11
  } trig_mode_e;

  localparam int unsigned FILT_CNT_W = 4;

  // Filter width in timer clocks for a select code.
  function automatic logic [FILT_CNT_W:0] filt_len(input logic [2:0] sel);
    case (sel)
      3'd0:    filt_len = 5'd2;
      3'd1:    filt_len = 5'd4;
      3'd2:    filt_len = 5'd8;
      default: filt_len = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/tmcore_trig_filter.sv
module tmcore_trig_filter
  import tmcore_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       pin,
  output logic       sync_o,
  output logic       filt_o
);

  logic       meta_q;
  logic       sync_q;
  logic       filt_q;
  logic [FILT_CNT_W-1:0] run_q;
  logic [FILT_CNT_W:0]   width;
  logic       last_step;

  assign width     = filt_len(sel);
  assign last_step = ({1'b0, run_q} == width - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
    end
  end

  // Count consecutive clocks where the synchronized level differs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_q != filt_q) begin
      if (last_step) begin
        filt_q <= sync_q;
        run_q  <= '0;
      end else begin
        run_q  <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;

endmodule

// File: rtl/tmcore_edge_sel.sv
module tmcore_edge_sel
  import tmcore_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       filt,
  output logic       edge_evt_o,
  output logic       level_hi_o
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= filt;
  end

  assign rise = filt & ~prev_q;
  assign fall = ~filt & prev_q;

  always_comb begin
    edge_evt_o = 1'b0;
    level_hi_o = 1'b0;
    case (trig_mode_e'(mode))
      TM_RISE:  edge_evt_o = rise;
      TM_FALL:  edge_evt_o = fall;
      TM_BOTH:  edge_evt_o = rise | fall;
      TM_LEVEL: level_hi_o = filt;
      default:  edge_evt_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmcore_shadow.sv
module tmcore_shadow #(
  parameter int unsigned CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_PERIOD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] buf_period_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o,
  output logic [CNT_W-1:0] dead_o
);

  localparam int unsigned NREG = 4;

  logic [CNT_W-1:0] buf_q [NREG];
  logic [CNT_W-1:0] act_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [CNT_W-1:0] RV = (i == 0) ? RST_PERIOD : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[i] <= RV;
        act_q[i] <= RV;
      end else begin
        if (wr_en && (wr_sel == 2'(i))) buf_q[i] <= wr_data;
        if (load) act_q[i] <= buf_q[i];
      end
    end
  end

  assign buf_period_o = buf_q[0];
  assign period_o     = act_q[0];
  assign cmp_a_o      = act_q[1];
  assign cmp_b_o      = act_q[2];
  assign dead_o       = act_q[3];

endmodule

// File: rtl/tmcore_trig_counter.sv
module tmcore_trig_counter
  import tmcore_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_PERIOD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic             stop_en,
  input  logic             clr_on_start,
  input  logic             clr_on_stop,
  input  logic [1:0]       trig_mode,
  input  logic [2:0]       filt_sel,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             estop,
  input  logic             estop_clr,
  input  logic             upd_req,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o,
  output logic [CNT_W-1:0] dead_o
);

  // Next count value for an advancing counter.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] per);
    next_count = (cur == per) ? '0 : cur + 1'b1;
  endfunction

  // Named internal events (observed by the checker).
  logic             sync_q;
  logic             filt;
  logic             edge_evt;
  logic             level_hi;
  logic             is_level;
  logic             start_evt;
  logic             stop_evt;
  logic             trig_clr;
  logic             halt;
  logic             counting;
  logic             adv;
  logic             wrap;
  logic             load;
  logic             estop_q;
  logic             pend_q;
  logic             run_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] buf_period;

  tmcore_trig_filter filt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (filt_sel),
    .pin    (trig_in),
    .sync_o (sync_q),
    .filt_o (filt)
  );

  tmcore_edge_sel edge_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (trig_mode),
    .filt       (filt),
    .edge_evt_o (edge_evt),
    .level_hi_o (level_hi)
  );

  tmcore_shadow #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) shadow_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .load         (load),
    .buf_period_o (buf_period),
    .period_o     (period_o),
    .cmp_a_o      (cmp_a_o),
    .cmp_b_o      (cmp_b_o),
    .dead_o       (dead_o)
  );

  assign is_level  = (trig_mode_e'(trig_mode) == TM_LEVEL);
  assign halt      = estop_q | estop;
  assign start_evt = edge_evt & start_en;
  assign stop_evt  = edge_evt & stop_en;
  assign trig_clr  = edge_evt & (clr_on_start | clr_on_stop) & ~halt;
  assign counting  = run_q & (is_level ? level_hi : 1'b1);
  assign adv       = counting & ~halt & ~trig_clr;
  assign wrap      = adv & (count_q == period_o);
  assign load      = pend_q & (trig_clr | wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      estop_q <= 1'b0;
    end else if (estop) begin
      estop_q <= 1'b1;
    end else if (estop_clr) begin
      estop_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= upd_req | (pend_q & ~load);
    end
  end

  // Run state: halt, then stop, then start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (stop_evt || sw_stop) begin
      run_q <= 1'b0;
    end else if (start_evt || sw_start) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (trig_clr) begin
      count_q <= '0;
    end else if (adv) begin
      count_q <= next_count(count_q, period_o);
    end
  end

  assign count_o = count_q;
  assign run_o   = run_q;

endmodule

// File: rtl/tmcore_trig_counter_chk.sv
module tmcore_trig_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       trig_mode,
  input logic             upd_req,
  input logic [CNT_W-1:0] count_o,
  input logic             run_o,
  input logic [CNT_W-1:0] period_o,
  input logic [CNT_W-1:0] buf_period,
  input logic             halt,
  input logic             wrap,
  input logic             trig_clr,
  input logic             load,
  input logic             pend_q,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sync_q,
  input logic             filt
);

  // R2: a wrap lands on zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_o == '0));

  // R4: a trigger clear zeroes the count
  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    trig_clr |=> (count_o == '0));

  // R5: level mode never clears
  a_r5_level_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode == 2'b11) |-> !trig_clr);

  // R7: load copies the buffered period
  a_r7_load_from_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (period_o == $past(buf_period)));

  // R8: a consumed request drops
  a_r8_pending_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !upd_req) |=> !pend_q);

  // R9: halt freezes the count and the run state
  a_r9_estop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(count_o) && !run_o));

  // R3: stop wins over start
  a_r3_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && stop_evt && !halt) |=> !run_o);

  // R6: filter output only moves toward the synchronized input
  a_r6_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> (filt == $past(sync_q)));

endmodule

bind tmcore_trig_counter tmcore_trig_counter_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/tmcore_trig_counter_tb.sv
module tmcore_trig_counter_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_en = 0, stop_en = 0, clr_on_start = 0, clr_on_stop = 0;
  logic [1:0]   trig_mode = 2'b00;
  logic [2:0]   filt_sel = 3'd0;
  logic         sw_start = 0, sw_stop = 0, estop = 0, estop_clr = 0, upd_req = 0;
  logic         wr_en = 0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         trig_in = 1'b0;
  logic [W-1:0] count_o, period_o, cmp_a_o, cmp_b_o, dead_o;
  logic         run_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmcore_trig_counter #(.CNT_W(W)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_ne(input string req, input int act, input int notv);
    total++;
    if (act == notv) begin
      bad++;
      $display("FAIL %s actual=%0d expected not %0d", req, act, notv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw(ref logic s);
    s = 1'b1; tick(1); s = 1'b0;
  endtask

  task automatic trig_pulse(input int len);
    trig_in = 1'b1; tick(len); trig_in = 1'b0; tick(24);
  endtask

  task automatic set_trig(input logic v);
    trig_in = v; tick(24);
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    wr_en = 1'b1; wr_sel = s; wr_data = W'(d); tick(1); wr_en = 1'b0;
  endtask

  task automatic make_nonzero();
    pulse_sw(sw_start); tick(10); pulse_sw(sw_stop); tick(2);
  endtask

  function automatic int fwidth(input int s);
    return (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, c1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 run", run_o, 0);
    check("R1 period", period_o, 255);
    check("R1 cmpA", cmp_a_o, 0);
    check("R1 cmpB", cmp_b_o, 0);
    check("R1 dead", dead_o, 0);

    // R6 filter sweep, R4 clear without start enable
    clr_on_start = 1'b1;
    for (int s = 0; s < 5; s++) begin
      filt_sel = 3'(s);
      make_nonzero();
      c0 = count_o;
      trig_pulse(fwidth(s) - 1);
      check("R6 short pulse ignored", count_o, c0);
      trig_pulse(fwidth(s));
      check("R6/R4 full pulse clears", count_o, 0);
      check("R4 clear does not start", run_o, 0);
    end
    filt_sel = 3'd0;

    // R5 falling and both modes
    trig_mode = 2'b01;
    make_nonzero(); c0 = count_o;
    set_trig(1'b1);
    check("R5 fall mode ignores rise", count_o, c0);
    set_trig(1'b0);
    check("R5 fall mode clears on fall", count_o, 0);
    trig_mode = 2'b10;
    make_nonzero();
    set_trig(1'b1);
    check("R5 both mode clears on rise", count_o, 0);
    make_nonzero();
    set_trig(1'b0);
    check("R5 both mode clears on fall", count_o, 0);
    trig_mode = 2'b00;

    // R4 clear on stop trigger with stop disabled
    clr_on_start = 1'b0; clr_on_stop = 1'b1;
    make_nonzero(); c0 = count_o;
    check_ne("R4 setup nonzero", c0, 0);
    trig_pulse(4);
    check("R4 clear on stop trigger", count_o, 0);
    clr_on_stop = 1'b0;

    // R3 start trigger, stop trigger, stop wins
    start_en = 1'b1;
    trig_pulse(4);
    check("R3 start trigger runs", run_o, 1);
    start_en = 1'b0; stop_en = 1'b1;
    trig_pulse(4);
    check("R3 stop trigger halts", run_o, 0);
    c0 = count_o; tick(3);
    check("R3 stopped count stable", count_o, c0);
    start_en = 1'b1;
    trig_pulse(4);
    check("R3 stop wins over start", run_o, 0);
    start_en = 1'b0; stop_en = 1'b0;
    sw_start = 1'b1; sw_stop = 1'b1; tick(1); sw_start = 1'b0; sw_stop = 1'b0;
    check("R3 sw stop wins", run_o, 0);

    // R5 level mode
    trig_mode = 2'b11; clr_on_start = 1'b1; start_en = 1'b1; stop_en = 1'b1;
    pulse_sw(sw_start); tick(2);
    c0 = count_o; tick(5);
    check("R5 level low holds", count_o, c0);
    trig_pulse(20);
    c1 = count_o;
    check("R5 level counts high clocks", (c1 - c0) & 255, 20);
    check("R5 level no start/stop", run_o, 1);
    pulse_sw(sw_stop);
    trig_mode = 2'b00; start_en = 1'b0; stop_en = 1'b0;

    // R9 emergency stop
    pulse_sw(sw_start); tick(5);
    pulse_sw(estop);
    c0 = count_o; tick(3);
    check("R9 halt holds count", count_o, c0);
    check("R9 halt clears run", run_o, 0);
    trig_pulse(4);
    check("R9 no clear while halted", count_o, c0);
    check_ne("R9 count not zeroed", count_o, 0);
    pulse_sw(sw_start); tick(3);
    check("R9 latched blocks start", count_o, c0);
    pulse_sw(estop_clr); tick(3);
    check("R9 release alone stays stopped", count_o, c0);
    pulse_sw(sw_start); tick(3);
    check("R9 restart counts", count_o, (c0 + 3) & 255);
    pulse_sw(sw_stop);

    // R7/R8 shadow loading
    wr(2'd0, 9); wr(2'd1, 3); wr(2'd2, 6); wr(2'd3, 2);
    pulse_sw(upd_req); tick(5);
    check("R8 no load without event", period_o, 255);
    trig_pulse(4);
    check("R7 period loaded", period_o, 9);
    check("R7 cmpA loaded", cmp_a_o, 3);
    check("R7 cmpB loaded", cmp_b_o, 6);
    check("R7 dead loaded", dead_o, 2);
    wr(2'd1, 7);
    trig_pulse(4);
    check("R7 no pending no load", cmp_a_o, 3);

    // R2 wrap sweep
    for (int p = 0; p < 8; p++) begin
      wr(2'd0, p); pulse_sw(upd_req);
      trig_pulse(4);
      check("R7 sweep period", period_o, p);
      sw_start = 1'b1; tick(1); sw_start = 1'b0;
      check("R2 start value", count_o, 0);
      for (int k = 1; k <= 2 * (p + 1) + 1; k++) begin
        tick(1);
        check("R2 wrap sequence", count_o, k % (p + 1));
      end
      pulse_sw(sw_stop);
    end

    // R8 update applied at wrap
    clr_on_start = 1'b0;
    pulse_sw(sw_start);
    wr(2'd0, 5); pulse_sw(upd_req);
    check("R8 not before wrap", period_o, 7);
    tick(10);
    check("R8 applied at wrap", period_o, 5);
    wr(2'd0, 3); tick(20);
    check("R8 request dropped", period_o, 5);
    pulse_sw(sw_stop);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule